// File: doc/BRIEF.md
# Fuse Array Register Controller

This block is the register front end for a one-time-programmable fuse array of 1024 bytes. Software talks to it through a small 32-bit register bus. It can read one fuse byte into a data register, or burn a single fuse bit. A burn only happens after a two-step unlock. Each operation takes a fixed number of clock cycles. During that time a ready flag is low. When the operation ends, a sticky completion flag is set, and this flag can raise an interrupt.

The fuse array sits outside the block. The controller drives a byte address, a bit position, a read enable and a one-cycle program strobe, and it samples the byte the array returns. A configuration bit blocks all reads and burns in the lowest 256 bytes. Software can wipe the data register so that no fuse byte stays readable. A separate key-select register holds a key size and a key index, and it reports a valid flag a few cycles after each write.

Top module: `fusebox_ctrl`

## Requirements
- R1: After reset the status register reads 0x1 (ready set, completion flag clear, interrupt enable clear). The data, address, configuration and key registers read 0, and `irq` is low.
- R2: A write of 0x02 to the control register (index 0) while ready starts a read. Ready (status bit 0) stays low for exactly OP_CYCLES cycles. The data register (index 3) then holds the addressed fuse byte in bits 7:0, and its upper bits read 0.
- R3: The value 0x1 written to the control register, followed by 0xBF79E5D0 as the very next control write, starts a burn, provided the address register has its staged bit set. The burn sets only the addressed bit of the addressed byte.
- R4: If the control write after 0x1 is any value other than 0xBF79E5D0, the arm is cancelled and nothing else happens. The unlock word with no arm before it also does nothing.
- R5: Control writes made while ready is low are ignored. They neither arm the unlock nor start an operation.
- R6: Writing 0x01 to the data register clears it to 0. Any other value written there has no effect.
- R7: Status bit 1 is set when an operation completes, and writing 1 to it clears it. Status bit 2 is a read/write interrupt enable. `irq` is high exactly when both bits are 1.
- R8: While configuration bit 31 (index 4) is set, a read of a byte below 256 returns 0 and a burn there leaves the array unchanged. Bytes from 256 upward are not affected.
- R9: The key register (index 5) stores a key size in bits 6:4 and a key index in bits 19:18, and reads its other bits as 0 apart from bit 0. Bit 0 is the valid flag. A write clears it, and it reads 1 again KEY_CYCLES cycles later.
- R10: A correct unlock sequence issued while the address register's staged bit (bit 16) is clear starts no burn. Ready stays high and the array is unchanged.
- R11: The address register (index 2) holds the byte address in bits 9:0, the bit position in bits 12:10 and the staged flag in bit 16. Writes to it, and to the configuration register, are ignored while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_idx | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_idx` (combinational) |
| irq | output | 1 | Completion interrupt |
| fa_byte | output | 10 | Byte address to the fuse array |
| fa_bit | output | 3 | Bit position to the fuse array |
| fa_rd_en | output | 1 | Read cycle in progress |
| fa_pgm_en | output | 1 | One-cycle burn strobe |
| fa_rdata | input | 8 | Byte returned by the fuse array |

## Verification
The bench checks the edges of the protected window at bytes 255 and 256, both with the protection bit on and with it off. A wrong comparison would either leak a protected byte or zero a byte that should read normally. It breaks the unlock in three ways: an arm followed by a wrong word, the unlock word with no arm before it, and an arm sent while busy. In each case it then checks that the target byte is unchanged, because a loose arm would burn a fuse. It also checks that an address write during a busy cycle is dropped, and that a wipe clears the data register while other values written there leave it alone. Finally, it measures how long ready stays low and when the key valid flag returns, so an off-by-one counter is caught.

// File: rtl/fusebox_pkg.sv
`timescale 1ns/1ps
package fusebox_pkg;
    // register indices on the bus
    localparam logic [2:0] IDX_CTL  = 3'd0;
    localparam logic [2:0] IDX_STAT = 3'd1;
    localparam logic [2:0] IDX_ADDR = 3'd2;
    localparam logic [2:0] IDX_DATA = 3'd3;
    localparam logic [2:0] IDX_CFG  = 3'd4;
    localparam logic [2:0] IDX_KEY  = 3'd5;

    // command and special values
    localparam logic [31:0] CMD_READ   = 32'h0000_0002;
    localparam logic [31:0] CMD_ARM    = 32'h0000_0001;
    localparam logic [31:0] CMD_UNLOCK = 32'hBF79_E5D0;
    localparam logic [31:0] DATA_WIPE  = 32'h0000_0001;

    // field positions
    localparam int STAT_RDY       = 0;
    localparam int STAT_STICKY    = 1;
    localparam int STAT_IEN       = 2;
    localparam int ADDR_BIT_LSB   = 10;
    localparam int ADDR_STAGE_POS = 16;
    localparam int CFG_DIS_POS    = 31;
    localparam int KEY_VALID_POS  = 0;
    localparam int KEY_SIZE_LSB   = 4;
    localparam int KEY_IDX_LSB    = 18;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_READ = 2'd1,
        OP_PROG = 2'd2
    } fuse_op_e;
endpackage

// File: rtl/fusebox_unlock.sv
`timescale 1ns/1ps
module fusebox_unlock
    import fusebox_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    output logic        go_read,
    output logic        go_prog,
    output logic        armed
);
    typedef struct packed {
        logic armed;
    } unlock_t;

    unlock_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        go_read = 1'b0;
        go_prog = 1'b0;
        if (ctl_we) begin
            if (st_q.armed) begin
                // second write of the pair: only the exact word proceeds
                st_d.armed = 1'b0;
                go_prog    = (ctl_wdata == CMD_UNLOCK);
            end else begin
                st_d.armed = (ctl_wdata == CMD_ARM);
                go_read    = (ctl_wdata == CMD_READ);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = st_q.armed;
endmodule

// File: rtl/fusebox_seq.sv
`timescale 1ns/1ps
module fusebox_seq
    import fusebox_pkg::*;
#(
    parameter int BYTE_AW   = 10,
    parameter int OP_CYCLES = 4,
    localparam int CNT_W    = $clog2(OP_CYCLES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_read,
    input  logic               go_prog,
    input  logic [BYTE_AW-1:0] byte_in,
    input  logic [2:0]         bit_in,
    input  logic               block_in,
    output logic               ready,
    output logic               fin,
    output logic               fin_read,
    output logic               fin_block,
    output logic [BYTE_AW-1:0] arr_byte,
    output logic [2:0]         arr_bit,
    output logic               arr_rd_en,
    output logic               arr_pgm_en
);
    typedef struct packed {
        fuse_op_e           op;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_AW-1:0] byte_a;
        logic [2:0]         bit_a;
        logic               block;
    } seq_t;

    seq_t s_d, s_q;
    logic done;

    always_comb begin
        s_d  = s_q;
        done = (s_q.op != OP_IDLE) && (s_q.cnt == '0);
        if (done) begin
            s_d.op = OP_IDLE;
        end else if (s_q.op != OP_IDLE) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (go_read || go_prog) begin
            s_d.op     = go_prog ? OP_PROG : OP_READ;
            s_d.cnt    = CNT_W'(OP_CYCLES - 1);
            s_d.byte_a = byte_in;
            s_d.bit_a  = bit_in;
            s_d.block  = block_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{op: OP_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign ready      = (s_q.op == OP_IDLE);
    assign fin        = done;
    assign fin_read   = done && (s_q.op == OP_READ);
    assign fin_block  = s_q.block;
    assign arr_byte   = s_q.byte_a;
    assign arr_bit    = s_q.bit_a;
    assign arr_rd_en  = (s_q.op == OP_READ);
    assign arr_pgm_en = done && (s_q.op == OP_PROG) && !s_q.block;
endmodule

// File: rtl/fusebox_keysel.sv
`timescale 1ns/1ps
module fusebox_keysel #(
    parameter int KEY_CYCLES = 3,
    localparam int KCNT_W    = $clog2(KEY_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_we,
    output logic kvalid
);
    typedef struct packed {
        logic              busy;
        logic [KCNT_W-1:0] cnt;
        logic              valid;
    } key_t;

    key_t k_d, k_q;

    always_comb begin
        k_d = k_q;
        if (key_we) begin
            k_d.valid = 1'b0;
            k_d.busy  = 1'b1;
            k_d.cnt   = KCNT_W'(KEY_CYCLES - 1);
        end else if (k_q.busy) begin
            if (k_q.cnt == '0) begin
                k_d.busy  = 1'b0;
                k_d.valid = 1'b1;
            end else begin
                k_d.cnt = k_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign kvalid = k_q.valid;
endmodule

// File: rtl/fusebox_ctrl.sv
`timescale 1ns/1ps
module fusebox_ctrl
    import fusebox_pkg::*;
#(
    parameter int ARRAY_BYTES = 1024,
    parameter int PROT_BYTES  = 256,
    parameter int OP_CYCLES   = 4,
    parameter int KEY_CYCLES  = 3,
    localparam int BYTE_AW    = $clog2(ARRAY_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [2:0]         bus_idx,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    output logic [BYTE_AW-1:0] fa_byte,
    output logic [2:0]         fa_bit,
    output logic               fa_rd_en,
    output logic               fa_pgm_en,
    input  logic [7:0]         fa_rdata
);
    localparam logic [31:0] PROT_LIM = 32'(PROT_BYTES);

    typedef struct packed {
        logic               sticky;
        logic               ien;
        logic [BYTE_AW-1:0] a_byte;
        logic [2:0]         a_bit;
        logic               stage;
        logic [7:0]         fdata;
        logic               cfg_dis;
        logic [2:0]         k_size;
        logic [1:0]         k_idx;
    } regs_t;

    regs_t r_d, r_q;

    logic seq_ready, seq_fin, seq_fin_read, seq_fin_block;
    logic ctl_we, key_we, go_read, go_prog, unl_armed, blk, kvalid;
    logic sticky_w, cfg_dis_w;
    logic [7:0] fdata_w;

    assign ctl_we = bus_we && (bus_idx == IDX_CTL) && seq_ready;
    assign key_we = bus_we && (bus_idx == IDX_KEY);
    assign blk    = r_q.cfg_dis && (32'(r_q.a_byte) < PROT_LIM);

    fusebox_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (bus_wdata),
        .go_read   (go_read),
        .go_prog   (go_prog),
        .armed     (unl_armed)
    );

    fusebox_seq #(
        .BYTE_AW   (BYTE_AW),
        .OP_CYCLES (OP_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_read    (go_read),
        .go_prog    (go_prog && r_q.stage),
        .byte_in    (r_q.a_byte),
        .bit_in     (r_q.a_bit),
        .block_in   (blk),
        .ready      (seq_ready),
        .fin        (seq_fin),
        .fin_read   (seq_fin_read),
        .fin_block  (seq_fin_block),
        .arr_byte   (fa_byte),
        .arr_bit    (fa_bit),
        .arr_rd_en  (fa_rd_en),
        .arr_pgm_en (fa_pgm_en)
    );

    fusebox_keysel #(
        .KEY_CYCLES (KEY_CYCLES)
    ) u_keysel (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_we (key_we),
        .kvalid (kvalid)
    );

    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            case (bus_idx)
                IDX_STAT: begin
                    r_d.ien = bus_wdata[STAT_IEN];
                    if (bus_wdata[STAT_STICKY]) r_d.sticky = 1'b0;
                end
                IDX_ADDR: begin
                    if (seq_ready) begin
                        r_d.a_byte = bus_wdata[BYTE_AW-1:0];
                        r_d.a_bit  = bus_wdata[ADDR_BIT_LSB +: 3];
                        r_d.stage  = bus_wdata[ADDR_STAGE_POS];
                    end
                end
                IDX_DATA: begin
                    if (bus_wdata == DATA_WIPE) r_d.fdata = '0;
                end
                IDX_CFG: begin
                    if (seq_ready) r_d.cfg_dis = bus_wdata[CFG_DIS_POS];
                end
                IDX_KEY: begin
                    r_d.k_size = bus_wdata[KEY_SIZE_LSB +: 3];
                    r_d.k_idx  = bus_wdata[KEY_IDX_LSB +: 2];
                end
                default: ;
            endcase
        end
        // completion wins over a same-cycle software clear
        if (seq_fin)      r_d.sticky = 1'b1;
        if (seq_fin_read) r_d.fdata  = seq_fin_block ? 8'h00 : fa_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_idx)
            IDX_STAT: begin
                bus_rdata[STAT_RDY]    = seq_ready;
                bus_rdata[STAT_STICKY] = r_q.sticky;
                bus_rdata[STAT_IEN]    = r_q.ien;
            end
            IDX_ADDR: begin
                bus_rdata[BYTE_AW-1:0]         = r_q.a_byte;
                bus_rdata[ADDR_BIT_LSB +: 3]   = r_q.a_bit;
                bus_rdata[ADDR_STAGE_POS]      = r_q.stage;
            end
            IDX_DATA: bus_rdata[7:0] = r_q.fdata;
            IDX_CFG:  bus_rdata[CFG_DIS_POS] = r_q.cfg_dis;
            IDX_KEY: begin
                bus_rdata[KEY_VALID_POS]     = kvalid;
                bus_rdata[KEY_SIZE_LSB +: 3] = r_q.k_size;
                bus_rdata[KEY_IDX_LSB +: 2]  = r_q.k_idx;
            end
            default: ;
        endcase
    end

    assign irq       = r_q.sticky && r_q.ien;
    assign sticky_w  = r_q.sticky;
    assign cfg_dis_w = r_q.cfg_dis;
    assign fdata_w   = r_q.fdata;
endmodule

// File: rtl/fusebox_ctrl_chk.sv
`timescale 1ns/1ps
module fusebox_ctrl_chk
    import fusebox_pkg::*;
#(
    parameter int BYTE_AW    = 10,
    parameter int PROT_BYTES = 256
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic [2:0]         bus_idx,
    input logic [31:0]        bus_wdata,
    input logic               seq_ready,
    input logic               seq_fin,
    input logic               fa_pgm_en,
    input logic [BYTE_AW-1:0] fa_byte,
    input logic               cfg_dis,
    input logic               sticky,
    input logic [7:0]         fdata,
    input logic               kvalid
);
    localparam logic [31:0] PROT_LIM = 32'(PROT_BYTES);

    // R3: a burn strobe only occurs inside an operation
    p_pgm_in_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fa_pgm_en |-> !seq_ready);

    // R8: no burn strobe reaches the protected window
    p_pgm_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fa_pgm_en |-> !(cfg_dis && (32'(fa_byte) < PROT_LIM)));

    // R5: ready only drops after a control write
    p_start_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_ready) |-> $past(bus_we && (bus_idx == IDX_CTL)));

    // R7: completion leaves the sticky flag set
    p_fin_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fin |=> sticky);

    // R6: a wipe while idle empties the data register
    p_wipe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_idx == IDX_DATA) && (bus_wdata == DATA_WIPE) && seq_ready)
        |=> (fdata == 8'h00));

    // R9: a key write drops the valid flag
    p_key_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_idx == IDX_KEY)) |=> !kvalid);

    // R11: the array address holds during an operation
    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_ready && $past(!seq_ready)) |-> $stable(fa_byte));
endmodule

bind fusebox_ctrl fusebox_ctrl_chk #(
    .BYTE_AW    (BYTE_AW),
    .PROT_BYTES (PROT_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_idx   (bus_idx),
    .bus_wdata (bus_wdata),
    .seq_ready (seq_ready),
    .seq_fin   (seq_fin),
    .fa_pgm_en (fa_pgm_en),
    .fa_byte   (fa_byte),
    .cfg_dis   (cfg_dis_w),
    .sticky    (sticky_w),
    .fdata     (fdata_w),
    .kvalid    (kvalid)
);

// File: tb/fusebox_ctrl_bench.sv
`timescale 1ns/1ps
module fusebox_ctrl_bench;
    import fusebox_pkg::*;

    localparam int OPC    = 4;
    localparam int KEYC   = 3;
    localparam int NBYTES = 1024;
    localparam int PROT   = 256;

    logic        clk, rst_n, bus_we;
    logic [2:0]  bus_idx;
    logic [31:0] bus_wdata, bus_rdata;
    logic        irq, fa_rd_en, fa_pgm_en;
    logic [9:0]  fa_byte;
    logic [2:0]  fa_bit;
    logic [7:0]  fa_rdata;
    logic [7:0]  fmem [NBYTES];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    fusebox_ctrl #(
        .ARRAY_BYTES (NBYTES),
        .PROT_BYTES  (PROT),
        .OP_CYCLES   (OPC),
        .KEY_CYCLES  (KEYC)
    ) u_fusebox_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .fa_byte   (fa_byte),
        .fa_bit    (fa_bit),
        .fa_rd_en  (fa_rd_en),
        .fa_pgm_en (fa_pgm_en),
        .fa_rdata  (fa_rdata)
    );

    // behavioural fuse array: bits only go from 0 to 1
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) fmem[i] <= pat(i);
        end else if (fa_pgm_en) begin
            fmem[fa_byte][fa_bit] <= 1'b1;
        end
    end
    assign fa_rdata = fmem[fa_byte];

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // {protect, byte}
    localparam logic [10:0] VEC [8] = '{
        {1'b0, 10'd0},   {1'b0, 10'd255}, {1'b0, 10'd256}, {1'b0, 10'd1023},
        {1'b1, 10'd0},   {1'b1, 10'd255}, {1'b1, 10'd256}, {1'b1, 10'd700}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] val);
        bus_we    = 1'b1;
        bus_idx   = idx;
        bus_wdata = val;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        bus_idx = idx;
        #0.01;
        val = bus_rdata;
    endtask

    task automatic do_read(input int b, output logic [31:0] val);
        wr(IDX_ADDR, 32'(b));
        wr(IDX_CTL, CMD_READ);
        repeat (OPC) @(negedge clk);
        rd(IDX_DATA, val);
    endtask

    task automatic do_prog(input int b, input int bt, input bit staged);
        wr(IDX_ADDR, 32'(b) | (32'(bt) << 10) | (staged ? 32'h0001_0000 : 32'h0));
        wr(IDX_CTL, CMD_ARM);
        wr(IDX_CTL, CMD_UNLOCK);
        repeat (OPC) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  e;
        bus_we = 1'b0; bus_idx = '0; bus_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(IDX_STAT, v); chk("R1 status", v, 32'h1);
        rd(IDX_DATA, v); chk("R1 data", v, 32'h0);
        rd(IDX_ADDR, v); chk("R1 addr", v, 32'h0);
        rd(IDX_CFG,  v); chk("R1 cfg", v, 32'h0);
        rd(IDX_KEY,  v); chk("R1 key", v, 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 / R8 table of reads with and without the protected window
        for (int k = 0; k < 8; k++) begin
            logic dis;
            int   b;
            dis = VEC[k][10];
            b   = int'(VEC[k][9:0]);
            wr(IDX_CFG, {dis, 31'b0});
            wr(IDX_ADDR, 32'(b));
            wr(IDX_CTL, CMD_READ);
            rd(IDX_STAT, v); chk("R2 ready low at start", 32'(v[0]), 32'h0);
            repeat (OPC - 1) @(negedge clk);
            rd(IDX_STAT, v); chk("R2 ready low at last cycle", 32'(v[0]), 32'h0);
            @(negedge clk);
            rd(IDX_STAT, v); chk("R2 ready back", 32'(v[0]), 32'h1);
            chk("R7 sticky after read", 32'(v[1]), 32'h1);
            rd(IDX_DATA, v);
            e = (dis && b < PROT) ? 8'h00 : pat(b);
            chk("R2/R8 read data", v, {24'h0, e});
        end
        wr(IDX_CFG, 32'h0);

        // R3 burn a clear bit
        do_prog(300, 1, 1'b1);
        do_read(300, v); chk("R3 burn bit", v, {24'h0, pat(300) | 8'h02});

        // R4 arm then wrong word, then orphan unlock word
        wr(IDX_ADDR, 32'd500 | (32'd1 << 10) | 32'h0001_0000);
        wr(IDX_CTL, CMD_ARM);
        wr(IDX_CTL, 32'h3);
        rd(IDX_STAT, v); chk("R4 wrong word no op", 32'(v[0]), 32'h1);
        wr(IDX_CTL, CMD_UNLOCK);
        rd(IDX_STAT, v); chk("R4 orphan unlock no op", 32'(v[0]), 32'h1);
        repeat (OPC) @(negedge clk);
        do_read(500, v); chk("R4 array unchanged", v, {24'h0, pat(500)});

        // R5 / R11 writes during a busy read are dropped
        wr(IDX_ADDR, 32'd600 | (32'd1 << 10) | 32'h0001_0000);
        wr(IDX_CTL, CMD_READ);
        wr(IDX_CTL, CMD_ARM);
        wr(IDX_ADDR, 32'd7);
        repeat (OPC) @(negedge clk);
        rd(IDX_ADDR, v); chk("R11 busy addr write dropped", v, 32'h0001_0000 | (32'd1 << 10) | 32'd600);
        rd(IDX_DATA, v); chk("R2 busy read result", v, {24'h0, pat(600)});
        wr(IDX_CTL, CMD_UNLOCK);
        rd(IDX_STAT, v); chk("R5 busy arm ignored", 32'(v[0]), 32'h1);
        repeat (OPC) @(negedge clk);
        do_read(600, v); chk("R5 array unchanged", v, {24'h0, pat(600)});

        // R10 unlock without staged bit
        wr(IDX_ADDR, 32'd700 | (32'd1 << 10));
        wr(IDX_CTL, CMD_ARM);
        wr(IDX_CTL, CMD_UNLOCK);
        rd(IDX_STAT, v); chk("R10 no op unstaged", 32'(v[0]), 32'h1);
        repeat (OPC) @(negedge clk);
        do_read(700, v); chk("R10 array unchanged", v, {24'h0, pat(700)});

        // R6 data wipe
        wr(IDX_DATA, 32'h55);
        rd(IDX_DATA, v); chk("R6 other value ignored", v, {24'h0, pat(700)});
        wr(IDX_DATA, DATA_WIPE);
        rd(IDX_DATA, v); chk("R6 wipe", v, 32'h0);

        // R8 burns inside and outside the window
        wr(IDX_CFG, 32'h8000_0000);
        do_prog(10, 3, 1'b1);
        do_prog(400, 1, 1'b1);
        wr(IDX_CFG, 32'h0);
        do_read(10, v);  chk("R8 protected burn blocked", v, {24'h0, pat(10)});
        do_read(400, v); chk("R8 burn above window", v, {24'h0, pat(400) | 8'h02});

        // R7 sticky and interrupt enable
        rd(IDX_STAT, v); chk("R7 status idle", v, 32'h3);
        chk("R7 irq off", 32'(irq), 32'h0);
        wr(IDX_STAT, 32'h4);
        rd(IDX_STAT, v); chk("R7 ien set", v, 32'h7);
        chk("R7 irq on", 32'(irq), 32'h1);
        wr(IDX_STAT, 32'h6);
        rd(IDX_STAT, v); chk("R7 w1c", v, 32'h5);
        chk("R7 irq cleared", 32'(irq), 32'h0);
        do_read(5, v);
        chk("R7 irq after op", 32'(irq), 32'h1);

        // R9 key select
        wr(IDX_KEY, 32'h000C_0060);
        rd(IDX_KEY, v); chk("R9 valid dropped", v, 32'h000C_0060);
        repeat (KEYC - 1) @(negedge clk);
        rd(IDX_KEY, v); chk("R9 valid still low", v, 32'h000C_0060);
        @(negedge clk);
        rd(IDX_KEY, v); chk("R9 valid returns", v, 32'h000C_0061);
        wr(IDX_KEY, 32'hFFFF_FFFF);
        repeat (KEYC) @(negedge clk);
        rd(IDX_KEY, v); chk("R9 fields only", v, 32'h000C_0071);

        // R11 address fields
        wr(IDX_ADDR, 32'hFFFF_FFFF);
        rd(IDX_ADDR, v); chk("R11 field mask", v, 32'h0001_1FFF);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule